// File: doc/BRIEF.md
# Programmable Square-Wave Clock Output

This block produces a square wave for a pad that can only pull low or let go. A base tick, a one-cycle enable pulse at the 32.768 kHz rate, drives one binary counter. Three taps of that counter give 1.024 kHz, 32 Hz and 1 Hz. A fourth choice passes the base rate straight through. A single control register, written over a simple write strobe, picks the tap and says whether the pad is driven at all. When the pad is off, it is released to high impedance and an external pull-up holds it high.

A new setting is held as pending and only becomes active at a safe point. For an active output, that point is the end of the current period, which is the moment a new low phase would begin. The counter restarts at that moment, so the new wave opens with a full low phase. For a released output, the safe point is the next base tick. No shortened pulse therefore reaches the pad. After reset the output is enabled on the undivided tap.

Top module: `sqwave_gen`

## Requirements
- R1: A write is accepted only when `cfg_wr` is high and `cfg_addr` equals `CTRL_ADDR` (default 4'hD). In an accepted write, `cfg_wdata[7]` is the enable, `cfg_wdata[1:0]` is the select and bits 6:2 are ignored. Writes to any other address change nothing.
- R2: Reset leaves the output enabled on select 00 with the counter at zero. During reset and right after it, `pad_pull_low` and `pad_release` are both 0.
- R3: With select 00, `pad_pull_low` is high for exactly one clock after each base tick and low otherwise.
- R4: Selects 01, 10 and 11 give a period of 2^LOG2_T1, 2^LOG2_T2 and 2^LOG2_T3 base ticks (defaults 5, 10 and 15, which give 1.024 kHz, 32 Hz and 1 Hz). Each period is a low half followed by a high half of equal length.
- R5: A new select on an enabled output takes effect only at the end of the current period. The new wave then starts with a full low phase, so no phase is shorter than the shorter of the old and new nominal phases.
- R6: Clearing the enable lets the current period finish and then raises `pad_release`. While released, `pad_pull_low` stays 0.
- R7: Setting the enable while released takes effect at the next base tick. The output then starts with a full low phase of the selected tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the base (32.768 kHz) rate |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address of the write |
| cfg_wdata | input | 8 | Write data: bit 7 enable, bits 1:0 select |
| pad_pull_low | output | 1 | Pad driver pulls the line low |
| pad_release | output | 1 | Pad driver is high impedance (output disabled) |

## Verification
The bench builds the block with tap exponents 2, 3 and 5 and a base tick every third clock. Every wave is therefore at most 96 clocks long. This lets the bench run complete periods of all four selects, including a switch from the slowest tap, in a few hundred clocks. At that scale the bench can check the exact clock on which a pending switch or disable lands. A phase monitor then confirms that no phase shorter than nominal appears around a mid-phase switch.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;

  typedef enum logic [1:0] {
    TAP_BASE = 2'b00,
    TAP_DIV1 = 2'b01,
    TAP_DIV2 = 2'b10,
    TAP_DIV3 = 2'b11
  } tap_e;

  typedef struct packed {
    logic en;
    tap_e sel;
  } wave_cfg_t;

  localparam wave_cfg_t CFG_RESET = '{en: 1'b1, sel: TAP_BASE};

  // Period exponent (in base ticks) for a select value.
  function automatic int unsigned tap_log2(tap_e s, int unsigned l1,
                                           int unsigned l2, int unsigned l3);
    case (s)
      TAP_DIV1: return l1;
      TAP_DIV2: return l2;
      TAP_DIV3: return l3;
      default:  return 0;
    endcase
  endfunction

  // True when the counter sits in the last tick of a 2^lg-tick period.
  function automatic logic period_done(logic [31:0] c, int unsigned lg);
    logic [31:0] mask;
    mask = (32'd1 << lg) - 32'd1;
    return (c & mask) == mask;
  endfunction

  // True in the first half of a 2^lg-tick period.
  function automatic logic wave_low(logic [31:0] c, int unsigned lg);
    if (lg == 0) return 1'b0;
    return ((c >> (lg - 1)) & 32'd1) == 32'd0;
  endfunction

endpackage

// File: rtl/sqwave_cfg.sv
module sqwave_cfg
  import sqwave_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output wave_cfg_t         pend_cfg,
  output logic              ev_write
);

  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(CTRL_ADDR);

  assign ev_write = cfg_wr && (cfg_addr == HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg <= CFG_RESET;
    end else if (ev_write) begin
      pend_cfg.en  <= cfg_wdata[7];
      pend_cfg.sel <= tap_e'(cfg_wdata[1:0]);
    end
  end

endmodule

// File: rtl/sqwave_div.sv
module sqwave_div #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             base_ph
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      base_ph <= 1'b0;
    end else begin
      base_ph <= tick;
      if (tick) begin
        if (clear) cnt <= '0;
        else       cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sqwave_ctl.sv
module sqwave_ctl
  import sqwave_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned LOG2_T1 = 5,
  parameter int unsigned LOG2_T2 = 10,
  parameter int unsigned LOG2_T3 = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_cfg_t        pend_cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             base_ph,
  output wave_cfg_t        act_cfg,
  output logic             ev_period_end,
  output logic             ev_switch,
  output logic             pad_pull_low,
  output logic             pad_release
);

  int unsigned lg;
  logic [31:0] cnt_x;
  logic        lvl_low;

  assign cnt_x = 32'(cnt);

  always_comb begin
    lg            = tap_log2(act_cfg.sel, LOG2_T1, LOG2_T2, LOG2_T3);
    ev_period_end = tick && period_done(cnt_x, lg);
    ev_switch     = tick && (pend_cfg != act_cfg) &&
                    (!act_cfg.en || period_done(cnt_x, lg));
    lvl_low       = (act_cfg.sel == TAP_BASE) ? base_ph : wave_low(cnt_x, lg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_cfg <= CFG_RESET;
    else if (ev_switch) act_cfg <= pend_cfg;
  end

  assign pad_pull_low = act_cfg.en && lvl_low;
  assign pad_release  = !act_cfg.en;

endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen
  import sqwave_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 13,
  parameter int unsigned LOG2_T1   = 5,
  parameter int unsigned LOG2_T2   = 10,
  parameter int unsigned LOG2_T3   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic              pad_pull_low,
  output logic              pad_release
);

  localparam int unsigned CNT_W = (LOG2_T3 > 0) ? LOG2_T3 : 1;

  wave_cfg_t        pend_cfg;
  wave_cfg_t        act_cfg;
  logic             ev_write;
  logic             ev_switch;
  logic             ev_period_end;
  logic [CNT_W-1:0] cnt;
  logic             base_ph;

  sqwave_cfg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .pend_cfg (pend_cfg),
    .ev_write (ev_write)
  );

  sqwave_div #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clear  (ev_switch),
    .cnt    (cnt),
    .base_ph(base_ph)
  );

  sqwave_ctl #(
    .CNT_W(CNT_W), .LOG2_T1(LOG2_T1), .LOG2_T2(LOG2_T2), .LOG2_T3(LOG2_T3)
  ) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .pend_cfg     (pend_cfg),
    .cnt          (cnt),
    .base_ph      (base_ph),
    .act_cfg      (act_cfg),
    .ev_period_end(ev_period_end),
    .ev_switch    (ev_switch),
    .pad_pull_low (pad_pull_low),
    .pad_release  (pad_release)
  );

endmodule

// File: rtl/sqwave_gen_chk.sv
module sqwave_gen_chk
  import sqwave_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 13,
  parameter int unsigned CNT_W     = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              pad_pull_low,
  input logic              pad_release,
  input wave_cfg_t         pend_cfg,
  input wave_cfg_t         act_cfg,
  input logic              ev_switch,
  input logic [CNT_W-1:0]  cnt
);

  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(CTRL_ADDR);

  p_write_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == HIT) |=>
      (pend_cfg.en == $past(cfg_wdata[7]) && pend_cfg.sel == $past(cfg_wdata[1:0])));

  p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == HIT) |=> $stable(pend_cfg));

  p_reset_vals_r2: assert property (@(posedge clk)
    !rst_n |=> (act_cfg.en && act_cfg.sel == TAP_BASE && cnt == '0 &&
                !pad_pull_low && !pad_release));

  p_base_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_low && act_cfg.sel == TAP_BASE && !tick) |=> !pad_pull_low);

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_act_on_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg != $past(act_cfg)) |-> $past(ev_switch));

  p_restart_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_switch |=> (cnt == '0));

  p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_release) |-> $past(tick));

endmodule

bind sqwave_gen sqwave_gen_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .cfg_wr      (cfg_wr),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .pad_pull_low(pad_pull_low),
  .pad_release (pad_release),
  .pend_cfg    (pend_cfg),
  .act_cfg     (act_cfg),
  .ev_switch   (ev_switch),
  .cnt         (cnt)
);

// File: tb/sqwave_gen_bench.sv
module sqwave_gen_bench;

  localparam int unsigned AW   = 4;
  localparam int unsigned L1   = 2;
  localparam int unsigned L2   = 3;
  localparam int unsigned L3   = 5;
  localparam int          TDIV = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          pad_pull_low;
  logic          pad_release;

  int tests = 0;
  int fails = 0;

  sqwave_gen #(
    .ADDR_W(AW), .CTRL_ADDR(13), .LOG2_T1(L1), .LOG2_T2(L2), .LOG2_T3(L3)
  ) u_sqwave_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pad_pull_low(pad_pull_low), .pad_release(pad_release)
  );

  always #10 clk = ~clk;

  // base tick: one clock in every TDIV
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == 0);
      ph = (ph + 1) % TDIV;
    end
  end

  // phase-length monitor for the no-runt checks
  int  run_len_c = 0;
  bit  run_ok = 0;
  int  min_lo = 1000000;
  int  min_hi = 1000000;
  logic prev_lvl = 1'b0;
  logic prev_rel = 1'b0;

  always @(negedge clk) begin
    if (pad_pull_low != prev_lvl || pad_release != prev_rel) begin
      if (run_ok && !prev_rel) begin
        if (prev_lvl) min_lo = (run_len_c < min_lo) ? run_len_c : min_lo;
        else          min_hi = (run_len_c < min_hi) ? run_len_c : min_hi;
      end
      run_ok = 1;
      run_len_c = 1;
    end else begin
      run_len_c++;
    end
    prev_lvl = pad_pull_low;
    prev_rel = pad_release;
  end

  task automatic stats_clear();
    run_ok = 0;
    min_lo = 1000000;
    min_hi = 1000000;
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // wait for the first negedge of a new low phase; returns clocks waited
  task automatic sync_rise(output int waited);
    waited = 0;
    while (pad_pull_low) begin @(negedge clk); waited++; end
    while (!pad_pull_low) begin @(negedge clk); waited++; end
  endtask

  // starting at a first-low negedge, measure one low and one high phase
  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (pad_pull_low) begin lo++; @(negedge clk); end
    while (!pad_pull_low) begin hi++; @(negedge clk); end
  endtask

  function automatic int half(int unsigned lg);
    return TDIV * (1 << (lg - 1));
  endfunction

  task automatic t_reset();
    int w, lo, hi;
    @(negedge clk);
    chk("R2 pull_low in reset", int'(pad_pull_low), 0);
    chk("R2 release in reset", int'(pad_release), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 release after reset", int'(pad_release), 0);
    sync_rise(w);
    measure(lo, hi);
    chk("R3 base low clocks", lo, 1);
    chk("R3 base high clocks", hi, TDIV - 1);
  endtask

  task automatic t_taps();
    int w, lo, hi;
    int unsigned lgs[3] = '{L1, L2, L3};
    for (int s = 1; s <= 3; s++) begin
      wr(4'hD, 8'h80 | 8'(s));
      sync_rise(w);
      measure(lo, hi);
      measure(lo, hi);
      chk($sformatf("R4 sel %0d low", s), lo, half(lgs[s-1]));
      chk($sformatf("R4 sel %0d high", s), hi, half(lgs[s-1]));
    end
  endtask

  task automatic t_boundary();
    int w, lo, hi;
    // currently on select 11
    sync_rise(w);
    stats_clear();
    wr(4'hD, 8'h81);
    sync_rise(w);
    chk("R5 old period completes before switch", w + 2, 2 * half(L3));
    measure(lo, hi);
    chk("R5 new wave low after switch", lo, half(L1));
    chk("R5 new wave high after switch", hi, half(L1));
    // mid-low switch 01 -> 10
    repeat (3) @(negedge clk);
    stats_clear();
    wr(4'hD, 8'h82);
    repeat (80) @(negedge clk);
    chk("R5 no short low after mid-low switch", int'(min_lo >= half(L1)), 1);
    chk("R5 no short high after mid-low switch", int'(min_hi >= half(L1)), 1);
    // mid-high switch 10 -> 01
    sync_rise(w);
    repeat (half(L2) + 2) @(negedge clk);
    stats_clear();
    wr(4'hD, 8'h81);
    repeat (80) @(negedge clk);
    chk("R5 no short low after mid-high switch", int'(min_lo >= half(L1)), 1);
    chk("R5 no short high after mid-high switch", int'(min_hi >= half(L1)), 1);
  endtask

  task automatic t_disable();
    int w, seen;
    sync_rise(w);
    wr(4'hD, 8'h01);
    repeat (2 * half(L1) - 3) @(negedge clk);
    chk("R6 still driven before period end", int'(pad_release), 0);
    @(negedge clk);
    chk("R6 released at period end", int'(pad_release), 1);
    chk("R6 not pulled low at release", int'(pad_pull_low), 0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pad_pull_low || !pad_release) seen++;
    end
    chk("R6 stays released with no pull", seen, 0);
  endtask

  task automatic t_enable();
    int w, lo, hi;
    wr(4'hD, 8'h81);
    w = 0;
    while (!pad_pull_low) begin @(negedge clk); w++; end
    chk("R7 enable lands within one tick", int'(w <= TDIV), 1);
    chk("R7 release cleared", int'(pad_release), 0);
    measure(lo, hi);
    chk("R7 first low phase is full", lo, half(L1));
  endtask

  task automatic t_addr();
    int w, lo, hi;
    wr(4'hC, 8'h83);
    wr(4'hE, 8'h00);
    repeat (40) @(negedge clk);
    chk("R1 other address leaves enable", int'(pad_release), 0);
    sync_rise(w);
    measure(lo, hi);
    chk("R1 other address leaves select", lo, half(L1));
    // junk in bits 6:2 ignored: 0xFE -> enable, select 10
    wr(4'hD, 8'hFE);
    sync_rise(w);
    measure(lo, hi);
    measure(lo, hi);
    chk("R1 bits 6:2 ignored", lo, half(L2));
  endtask

  task automatic t_reset_mid();
    int w, lo, hi;
    wr(4'hD, 8'h03);
    w = 0;
    while (!pad_release && w < 200) begin @(negedge clk); w++; end
    chk("R6 released before mid reset", int'(pad_release), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 mid reset drives again", int'(pad_release), 0);
    chk("R2 mid reset no pull", int'(pad_pull_low), 0);
    rst_n = 1'b1;
    sync_rise(w);
    measure(lo, hi);
    chk("R2 base tap after mid reset", lo, 1);
    chk("R3 base high after mid reset", hi, TDIV - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_taps();
    t_boundary();
    t_disable();
    t_enable();
    t_addr();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule